// File: doc/BRIEF.md
# Transmit Packet Queue Manager

This block keeps track of packet buffer numbers for a buffered Ethernet transmit path. A small pool of equally sized packet buffers is tracked by a free bitmap. A host issues commands over a simple register-style interface: allocate a buffer, enqueue it for transmission, release it, and acknowledge a completed transmission. Each packet number moves from allocated, to queued in a pending-transmit FIFO, to completed in a completion FIFO that waits for the host's acknowledge.

The head of the pending queue is offered to a MAC-side port. The offer is gated by a transmit-enable bit and, in half-duplex operation, by a deferral input. The MAC answers with a one-cycle done or failed pulse. The block then writes a status word into the first word of that packet's buffer through a status-write port and moves the number to the completion FIFO. A failure also clears transmit-enable, so the queue stalls, and latches the failing number for the host. The host restarts by setting transmit-enable again and re-enqueueing.

Top module: `txq_mgr`

## Requirements
- R1: After reset all 16 packet numbers are free, both FIFOs are empty, and `tx_en`, `alloc_int`, `irq`, `tx_int`, `err`, `txfail`, `mac_req` and `st_we` are all 0.
- R2: An allocate command (`cmd_op`=1) whose length is within the buffer size grants the lowest free number. It also sets `alloc_int` and places the number on `alloc_result`, both visible after the next clock edge.
- R3: An allocate issued when no buffer is free clears `alloc_int` and leaves it clear. The request stays pending and is granted on the second clock edge after a release command, with the released number.
- R4: `irq` equals (`alloc_int` AND `alloc_mask`) OR `tx_int`.
- R5: An enqueue command (`cmd_op`=2) pushes the packet-number register (loaded via `pnr_wr`) into the pending FIFO. While transmission is allowed, `mac_req` is high after that edge and `mac_pkt` shows the oldest queued number.
- R6: `mac_req` is low while `tx_en` is 0, or while both `half_duplex` and `defer` are 1. In full duplex, `defer` has no effect.
- R7: A `mac_done` pulse during `mac_req` gives a one-cycle `st_we` after the edge, with `st_pkt` = the head number and `st_word` = 16'h0001. The number then moves to the completion FIFO, and `tx_int` is high. Packets complete in enqueue order.
- R8: A `mac_fail` pulse during `mac_req` writes `st_word` = 16'h0002. It clears `tx_en`, sets `txfail`, puts the number on `fail_pkt` and into the completion FIFO, and `mac_req` drops.
- R9: An acknowledge command (`cmd_op`=4) removes the completion-FIFO head shown on `cf_head`. `tx_int` is high exactly while that FIFO is non-empty.
- R10: A release command (`cmd_op`=3) returns the number in the packet-number register to the pool, where a later allocate can obtain it.
- R11: Writing `ctl_wr` with `ctl_txen`=1 sets `tx_en`, clears `txfail`, and resumes sending from the current pending head.
- R12: Acknowledge with an empty completion FIFO, or enqueue or release of a number that is free, is ignored and sets the sticky `err`. Only reset clears `err`.
- R13: An allocate with `cmd_len` above BUF_BYTES (2048) grants nothing, leaves no pending request and sets `err`. A length of exactly 2048 is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | 1 allocate, 2 enqueue, 3 release, 4 acknowledge |
| cmd_len | input | 12 | Requested byte count for allocate |
| pnr_wr | input | 1 | Load the packet-number register |
| pnr_wdata | input | 4 | Packet number to load |
| ctl_wr | input | 1 | Write transmit-enable |
| ctl_txen | input | 1 | New transmit-enable value |
| half_duplex | input | 1 | Half-duplex operation |
| defer | input | 1 | Deferral in progress |
| alloc_mask | input | 1 | Lets the allocation interrupt drive `irq` |
| alloc_int | output | 1 | Allocation-complete status |
| alloc_result | output | 4 | Last granted packet number |
| irq | output | 1 | Combined interrupt |
| tx_int | output | 1 | Completion FIFO non-empty |
| tx_en | output | 1 | Transmit-enable state |
| txfail | output | 1 | A transmission failed since the last enable |
| fail_pkt | output | 4 | Number of the failed packet |
| cf_head | output | 4 | Head of the completion FIFO |
| err | output | 1 | Sticky command error |
| mac_req | output | 1 | A packet is offered to the MAC |
| mac_pkt | output | 4 | Offered packet number |
| mac_done | input | 1 | Transmission succeeded (one cycle) |
| mac_fail | input | 1 | Transmission failed (one cycle) |
| st_we | output | 1 | Status word write strobe |
| st_pkt | output | 4 | Buffer receiving the status word |
| st_word | output | 16 | Status word value |

## Verification
Every result is due at a fixed point, and the checks keep to it. Command results (grant, queue push, pop, release, error flag) appear right after the edge that samples the command. A retried allocation lands one edge later than the release that enables it. The status write, completion push and enable clear follow one edge after the MAC pulse. `mac_req`, `irq` and `tx_int` are combinational from registered state and the gating inputs. The bench drives on the falling edge and checks at the next falling edge, or a step after changing a gating input. Allocation is swept over the whole pool, followed by exhaustion and retry, and the completion order is compared against the enqueue order.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ALLOC = 3'd1,
        OP_ENQ   = 3'd2,
        OP_REL   = 3'd3,
        OP_ACK   = 3'd4
    } txq_op_e;

    localparam int ST_OK_BIT   = 0;
    localparam int ST_FAIL_BIT = 1;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t s_q, s_d;
    logic  do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && (s_q.cnt != CW'(DEPTH));
        if (do_push) begin
            s_d.mem[s_q.wr] = wdata;
            s_d.wr          = step(s_q.wr);
        end
        if (do_pop) begin
            s_d.rd = step(s_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rd];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop)); // R5
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> !empty); // R7
endmodule

// File: rtl/txq_pool.sv
module txq_pool #(
    parameter int NPKT = 16,
    localparam int PW  = $clog2(NPKT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            rel_en,
    input  logic [PW-1:0]   rel_pkt,
    output logic            grant,
    output logic [PW-1:0]   grant_pkt,
    output logic [NPKT-1:0] free_vec
);
    logic [NPKT-1:0] free_q, free_d;

    always_comb begin
        grant     = 1'b0;
        grant_pkt = '0;
        for (int i = NPKT - 1; i >= 0; i--) begin
            if (req && free_q[i]) begin
                grant     = 1'b1;
                grant_pkt = PW'(i);
            end
        end
        free_d = free_q;
        if (grant)  free_d[grant_pkt] = 1'b0;
        if (rel_en) free_d[rel_pkt]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    assign free_vec = free_q;

    AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !free_q[$past(grant_pkt)]); // R2
    AST_REL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |=> free_q[$past(rel_pkt)]); // R10
endmodule

// File: rtl/txq_mgr.sv
module txq_mgr
    import txq_pkg::*;
#(
    parameter int NPKT      = 16,
    parameter int LENW      = 12,
    parameter int BUF_BYTES = 2048,
    parameter int SW        = 16,
    localparam int PW       = $clog2(NPKT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [LENW-1:0] cmd_len,
    input  logic            pnr_wr,
    input  logic [PW-1:0]   pnr_wdata,
    input  logic            ctl_wr,
    input  logic            ctl_txen,
    input  logic            half_duplex,
    input  logic            defer,
    input  logic            alloc_mask,
    output logic            alloc_int,
    output logic [PW-1:0]   alloc_result,
    output logic            irq,
    output logic            tx_int,
    output logic            tx_en,
    output logic            txfail,
    output logic [PW-1:0]   fail_pkt,
    output logic [PW-1:0]   cf_head,
    output logic            err,
    output logic            mac_req,
    output logic [PW-1:0]   mac_pkt,
    input  logic            mac_done,
    input  logic            mac_fail,
    output logic            st_we,
    output logic [PW-1:0]   st_pkt,
    output logic [SW-1:0]   st_word
);
    typedef struct packed {
        logic [PW-1:0] pnr;
        logic          alloc_pend;
        logic          alloc_int;
        logic [PW-1:0] alloc_res;
        logic          tx_en;
        logic          fail;
        logic [PW-1:0] fail_pkt;
        logic          err;
        logic          st_we;
        logic [PW-1:0] st_pkt;
        logic [SW-1:0] st_word;
    } mgr_t;

    mgr_t s_q, s_d;

    logic            c_alloc, c_enq, c_rel, c_ack, len_ok;
    logic            enq_ok, rel_ok, ack_ok;
    logic            pool_req, pool_grant;
    logic [PW-1:0]   pool_pkt;
    logic [NPKT-1:0] free_vec;
    logic [PW-1:0]   pf_head;
    logic            pf_empty, pf_full;
    logic            cf_empty, cf_full;
    logic            mac_end, mac_bad;

    always_comb begin
        c_alloc = cmd_valid && (cmd_op == OP_ALLOC);
        c_enq   = cmd_valid && (cmd_op == OP_ENQ);
        c_rel   = cmd_valid && (cmd_op == OP_REL);
        c_ack   = cmd_valid && (cmd_op == OP_ACK);
        len_ok  = (32'(cmd_len) <= BUF_BYTES);

        pool_req = s_q.alloc_pend || (c_alloc && len_ok);
        enq_ok   = c_enq && !free_vec[s_q.pnr] && !pf_full;
        rel_ok   = c_rel && !free_vec[s_q.pnr];
        ack_ok   = c_ack && !cf_empty;

        mac_req = !pf_empty && !cf_full && s_q.tx_en && !(half_duplex && defer);
        mac_end = mac_req && (mac_done || mac_fail);
        mac_bad = mac_req && mac_fail;
    end

    always_comb begin
        s_d       = s_q;
        s_d.st_we = 1'b0;

        if (pnr_wr) s_d.pnr = pnr_wdata;

        if (c_alloc) s_d.alloc_int = 1'b0;
        if (pool_grant) begin
            s_d.alloc_int  = 1'b1;
            s_d.alloc_res  = pool_pkt;
            s_d.alloc_pend = 1'b0;
        end else if (c_alloc && len_ok) begin
            s_d.alloc_pend = 1'b1;
        end

        if ((c_alloc && !len_ok) || (c_enq && !enq_ok) ||
            (c_rel && !rel_ok) || (c_ack && !ack_ok)) begin
            s_d.err = 1'b1;
        end

        if (ctl_wr) begin
            s_d.tx_en = ctl_txen;
            if (ctl_txen) s_d.fail = 1'b0;
        end

        if (mac_end) begin
            s_d.st_we   = 1'b1;
            s_d.st_pkt  = pf_head;
            s_d.st_word = '0;
            if (mac_bad) s_d.st_word[ST_FAIL_BIT] = 1'b1;
            else         s_d.st_word[ST_OK_BIT]   = 1'b1;
        end
        if (mac_bad) begin
            s_d.tx_en    = 1'b0;
            s_d.fail     = 1'b1;
            s_d.fail_pkt = pf_head;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    txq_pool #(.NPKT(NPKT)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (pool_req),
        .rel_en    (rel_ok),
        .rel_pkt   (s_q.pnr),
        .grant     (pool_grant),
        .grant_pkt (pool_pkt),
        .free_vec  (free_vec)
    );

    txq_fifo #(.W(PW), .DEPTH(NPKT)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (enq_ok),
        .wdata (s_q.pnr),
        .pop   (mac_end),
        .head  (pf_head),
        .empty (pf_empty),
        .full  (pf_full)
    );

    txq_fifo #(.W(PW), .DEPTH(NPKT)) u_cmpl (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (mac_end),
        .wdata (pf_head),
        .pop   (ack_ok),
        .head  (cf_head),
        .empty (cf_empty),
        .full  (cf_full)
    );

    assign tx_int       = !cf_empty;
    assign irq          = (s_q.alloc_int && alloc_mask) || tx_int;
    assign alloc_int    = s_q.alloc_int;
    assign alloc_result = s_q.alloc_res;
    assign tx_en        = s_q.tx_en;
    assign txfail       = s_q.fail;
    assign fail_pkt     = s_q.fail_pkt;
    assign err          = s_q.err;
    assign mac_pkt      = pf_head;
    assign st_we        = s_q.st_we;
    assign st_pkt       = s_q.st_pkt;
    assign st_word      = s_q.st_word;

    AST_FAIL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_req && mac_fail) |=> (!tx_en && txfail && !mac_req)); // R8
    AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_req && mac_done && !mac_fail) |=> (st_we && st_word[ST_OK_BIT] && tx_int)); // R7
    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (half_duplex && defer) |-> !mac_req); // R6
    AST_ACK_EMPTY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACK && !tx_int) |=> err); // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R12
    AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> $onehot(st_word[1:0])); // R7
endmodule

// File: tb/txq_mgr_tb.sv
module txq_mgr_tb;
    import txq_pkg::*;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [11:0] cmd_len;
    logic        pnr_wr;
    logic [3:0]  pnr_wdata;
    logic        ctl_wr, ctl_txen, half_duplex, defer, alloc_mask;
    logic        alloc_int, irq, tx_int, tx_en, txfail, err, mac_req, st_we;
    logic [3:0]  alloc_result, fail_pkt, cf_head, mac_pkt, st_pkt;
    logic [15:0] st_word;
    logic        mac_done, mac_fail;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P / 2) clk = ~clk;

    txq_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_len(cmd_len), .pnr_wr(pnr_wr), .pnr_wdata(pnr_wdata),
        .ctl_wr(ctl_wr), .ctl_txen(ctl_txen), .half_duplex(half_duplex),
        .defer(defer), .alloc_mask(alloc_mask), .alloc_int(alloc_int),
        .alloc_result(alloc_result), .irq(irq), .tx_int(tx_int), .tx_en(tx_en),
        .txfail(txfail), .fail_pkt(fail_pkt), .cf_head(cf_head), .err(err),
        .mac_req(mac_req), .mac_pkt(mac_pkt), .mac_done(mac_done),
        .mac_fail(mac_fail), .st_we(st_we), .st_pkt(st_pkt), .st_word(st_word)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = OP_NOP; cmd_len = 12'd64;
        pnr_wr = 1'b0; pnr_wdata = '0; ctl_wr = 1'b0; ctl_txen = 1'b0;
        half_duplex = 1'b0; defer = 1'b0; alloc_mask = 1'b1;
        mac_done = 1'b0; mac_fail = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic op(input txq_op_e o, input int len = 64);
        cmd_valid = 1'b1; cmd_op = o; cmd_len = 12'(len);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = OP_NOP;
    endtask

    task automatic setp(input int p);
        pnr_wr = 1'b1; pnr_wdata = 4'(p);
        @(negedge clk);
        pnr_wr = 1'b0;
    endtask

    task automatic set_en(input logic v);
        ctl_wr = 1'b1; ctl_txen = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic mac(input logic bad);
        mac_done = !bad; mac_fail = bad;
        @(negedge clk);
        mac_done = 1'b0; mac_fail = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seq[3];
        seq = '{3, 7, 9};
        do_reset();
        // R1 reset state
        chk("R1 alloc_int", alloc_int, 0); chk("R1 irq", irq, 0);
        chk("R1 tx_int", tx_int, 0);       chk("R1 tx_en", tx_en, 0);
        chk("R1 err", err, 0);             chk("R1 mac_req", mac_req, 0);
        chk("R1 st_we", st_we, 0);         chk("R1 txfail", txfail, 0);

        // R2 sweep over the pool: lowest free first
        for (int i = 0; i < 16; i++) begin
            op(OP_ALLOC);
            chk("R2 alloc_int", alloc_int, 1);
            chk("R2 alloc_result", alloc_result, i);
        end
        // R3 exhaustion and retry
        op(OP_ALLOC);
        chk("R3 no grant", alloc_int, 0);
        repeat (3) @(negedge clk);
        chk("R3 still none", alloc_int, 0);
        setp(5); op(OP_REL);
        chk("R3 not yet", alloc_int, 0);
        @(negedge clk);
        chk("R3 retry grant", alloc_int, 1);
        chk("R3 retry number", alloc_result, 5);

        // R4 interrupt masking
        alloc_mask = 1'b0; #1;
        chk("R4 masked", irq, 0);
        alloc_mask = 1'b1; #1;
        chk("R4 unmasked", irq, 1);

        // R5/R6 enqueue and gating
        setp(3); op(OP_ENQ);
        chk("R6 disabled", mac_req, 0);
        set_en(1'b1);
        chk("R5 req", mac_req, 1); chk("R5 pkt", mac_pkt, 3);
        setp(7); op(OP_ENQ); setp(9); op(OP_ENQ);
        half_duplex = 1'b1; defer = 1'b1; #1;
        chk("R6 defer half", mac_req, 0);
        half_duplex = 1'b0; #1;
        chk("R6 defer full", mac_req, 1);
        defer = 1'b0;

        // R7 completions in order
        foreach (seq[k]) begin
            chk("R7 head", mac_pkt, seq[k]);
            mac(1'b0);
            chk("R7 st_we", st_we, 1);
            chk("R7 st_pkt", st_pkt, seq[k]);
            chk("R7 st_word", st_word, 1);
            chk("R7 tx_int", tx_int, 1);
        end
        chk("R7 queue drained", mac_req, 0);
        @(negedge clk);
        chk("R7 pulse ends", st_we, 0);
        // R9 acknowledge order
        foreach (seq[k]) begin
            chk("R9 cf_head", cf_head, seq[k]);
            chk("R9 tx_int", tx_int, 1);
            op(OP_ACK);
        end
        chk("R9 empty", tx_int, 0);
        chk("R9 irq", irq, 1);
        chk("R12 no err", err, 0);

        // R8 failure halts
        setp(10); op(OP_ENQ); setp(11); op(OP_ENQ);
        chk("R8 head", mac_pkt, 10);
        mac(1'b1);
        chk("R8 st_word", st_word, 2);  chk("R8 st_pkt", st_pkt, 10);
        chk("R8 tx_en", tx_en, 0);      chk("R8 txfail", txfail, 1);
        chk("R8 fail_pkt", fail_pkt, 10);
        chk("R8 mac_req", mac_req, 0);  chk("R8 tx_int", tx_int, 1);
        chk("R8 cf_head", cf_head, 10);
        repeat (2) @(negedge clk);
        chk("R8 stays halted", mac_req, 0);

        // R11 restart
        op(OP_ACK);
        set_en(1'b1);
        chk("R11 txfail clr", txfail, 0);
        chk("R11 resume", mac_req, 1); chk("R11 pkt", mac_pkt, 11);
        setp(10); op(OP_ENQ);
        mac(1'b0); chk("R11 first", st_pkt, 11);
        mac(1'b0); chk("R11 retry", st_pkt, 10); chk("R11 word", st_word, 1);
        op(OP_ACK); op(OP_ACK);

        // R10 release then reallocate
        setp(10); op(OP_REL);
        op(OP_ALLOC);
        chk("R10 realloc", alloc_result, 10);
        chk("R10 int", alloc_int, 1);

        // R12 error cases
        chk("R12 clean", err, 0);
        op(OP_ACK);
        chk("R12 ack empty", err, 1);
        chk("R12 ack no effect", tx_int, 0);
        do_reset();
        setp(4); op(OP_ENQ);
        chk("R12 enq free", err, 1);
        set_en(1'b1);
        chk("R12 enq ignored", mac_req, 0);
        do_reset();
        setp(4); op(OP_REL);
        chk("R12 rel free", err, 1);
        op(OP_ALLOC);
        chk("R12 pool intact", alloc_result, 0);
        op(OP_ALLOC);
        chk("R12 pool next", alloc_result, 1);
        chk("R12 sticky", err, 1);

        // R13 length limit
        do_reset();
        op(OP_ALLOC, 4000);
        chk("R13 oversize err", err, 1);
        chk("R13 oversize none", alloc_int, 0);
        repeat (2) @(negedge clk);
        chk("R13 no pending", alloc_int, 0);
        op(OP_ALLOC, 2048);
        chk("R13 boundary", alloc_int, 1);
        chk("R13 number", alloc_result, 0);

        summary();
    end
endmodule